// File: doc/BRIEF.md
# Wide Register File with 16-bit Subword Access

This block is a small control/status register file whose registers are wider than the 16-bit CPU data bus. Each wide register is reached as a run of consecutive 16-bit subwords at rising byte addresses. The CPU reaches the block over a simple request bus: a request strobe, a byte address, a write enable and write data. The block answers each request with an acknowledge and read data one cycle later.

The block holds four registers:

- A 64-bit configuration register that software writes. Its fields drive hardware outputs.
- A 32-bit status register and a 64-bit monitor register. Hardware inputs supply their fields, and several fields cross a subword boundary.
- A 16-bit register with two 8-bit counters. Each counter records how many times software has accessed the subwords that hold one field of the monitor register.

Software assembles or splits a wide value one subword at a time. Each subword access touches only the bits inside its own 16-bit slice.

Top module: `wide_csr_file`

## Requirements
- R1: Every request sampled with `req_i` high gets `ack_o` high on the next cycle, and `ack_o` is low in every other cycle. `rdata_o` holds read data only in a cycle that acknowledges a read. In every other cycle `rdata_o` is zero.
- R2: Subword k of a register at base address B sits at byte address B+2k and holds bits 16k+15 to 16k of the register. Address bit 0 is ignored. The configuration register at 0x00 has these fields, each driving its own output: `cfg_byte_o` in bits 7:0, `cfg_mode_o` in bits 14:12, `cfg_en_o` in bit 36 and `cfg_thresh_o` in bits 47:40. All fields reset to zero.
- R3: A write to one configuration subword changes only the field bits inside that 16-bit slice. Writing 0x1234, 0x5678, 0x9ABC and 0xDEF1 to 0x00, 0x02, 0x04 and 0x06 gives byte 0x34, mode 1, enable 1 and threshold 0x9A.
- R4: Bits that belong to no field read as zero. After the writes in R3, the four configuration subwords read 0x1034, 0x0000, 0x9A10 and 0x0000.
- R5: The 32-bit status register at 0x20 shows `stat_a_i` (8 bits) in bits 19:12 and `stat_b_i` (11 bits) in bits 30:20. Inputs are captured on a clock edge, so a read issued one cycle after an input change returns the new value. With 0xAB and 0x4DE, 0x20 reads 0xB000 and 0x22 reads 0x4DEA.
- R6: The 64-bit monitor register at 0x28 shows `mon_a_i` (20 bits) in bits 31:12 and `mon_b_i` (2 bits) in bits 49:48. With 0xABCDE and 3, the four subwords read 0xE000, 0xABCD, 0x0000 and 0x0003.
- R7: Bit 3 of the status register is write-only. A write to 0x20 stores `wdata_i[3]` and drives it on `arm_o`, which resets to zero. A read of 0x20 always returns zero in bit 3.
- R8: The counter register at 0x30 holds a low counter in bits 7:0 and a high counter in bits 15:8. Each read or write to 0x28 or 0x2A adds one to the low counter. Each read or write to 0x2E adds one to the high counter. After each monitor subword is read twice, 0x30 reads 0x0204.
- R9: Both counters reset to zero, wrap from 0xFF to 0x00, and ignore software writes.
- R10: A read of an unmapped address returns zero. A write to an unmapped address or to a read-only bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Acknowledge, one cycle after the request |
| rdata_o | output | 16 | Read data, valid with a read acknowledge |
| cfg_byte_o | output | 8 | Configuration field, bits 7:0 |
| cfg_mode_o | output | 3 | Configuration field, bits 14:12 |
| cfg_en_o | output | 1 | Configuration field, bit 36 |
| cfg_thresh_o | output | 8 | Configuration field, bits 47:40 |
| arm_o | output | 1 | Write-only status bit |
| stat_a_i | input | 8 | Status field, bits 19:12 |
| stat_b_i | input | 11 | Status field, bits 30:20 |
| mon_a_i | input | 20 | Monitor field, bits 31:12 |
| mon_b_i | input | 2 | Monitor field, bits 49:48 |

## Verification
The hardest case to reach from the ports is counter wrap-around. It takes hundreds of monitor accesses, and none of them may land on the counter's own address. The stimulus first checks the 0x0204 pattern. It then issues enough extra reads of 0x28 to carry the low counter past 0xFF, and writes 0x2E to show that a write also counts. Straddling fields get the same kind of targeted stimulus: hardware values are chosen so that every nibble is nonzero, which exposes any slip in a slice boundary.

// File: rtl/wide_csr_pkg.sv
// Shared constants for the wide register file.
// Holds the bus width, the register base addresses and the field positions,
// plus constant functions that derive field masks and subword overlap from them.
// Assumes every register size is a whole number of bus subwords.
package wide_csr_pkg;

    localparam int BUS_W = 16;

    // Register base byte addresses and sizes in subwords
    localparam int CFG_BASE = 'h00;
    localparam int CFG_SUBS = 4;
    localparam int STS_BASE = 'h20;
    localparam int STS_SUBS = 2;
    localparam int MON_BASE = 'h28;
    localparam int MON_SUBS = 4;
    localparam int CNT_BASE = 'h30;
    localparam int CNT_SUBS = 1;

    // Field positions: least significant bit and width
    localparam int CFG_BYTE_LSB = 0;
    localparam int CFG_BYTE_W   = 8;
    localparam int CFG_MODE_LSB = 12;
    localparam int CFG_MODE_W   = 3;
    localparam int CFG_EN_LSB   = 36;
    localparam int CFG_THR_LSB  = 40;
    localparam int CFG_THR_W    = 8;
    localparam int ARM_LSB      = 3;
    localparam int STA_LSB      = 12;
    localparam int STA_W        = 8;
    localparam int STB_LSB      = 20;
    localparam int STB_W        = 11;
    localparam int MONA_LSB     = 12;
    localparam int MONA_W       = 20;
    localparam int MONB_LSB     = 48;
    localparam int MONB_W       = 2;
    localparam int CNT_W        = 8;

    typedef logic [BUS_W-1:0] subword_t;

    // Mask with WIDTH ones starting at bit LSB
    function automatic logic [63:0] span_mask(input int lsb, input int width);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
        return m;
    endfunction

    // True when subword SUB overlaps the field [LSB +: WIDTH]
    function automatic bit sub_overlaps(input int sub, input int lsb, input int width);
        return (sub*BUS_W <= lsb+width-1) && (sub*BUS_W+BUS_W-1 >= lsb);
    endfunction

    localparam logic [63:0] CFG_MASK = span_mask(CFG_BYTE_LSB, CFG_BYTE_W)
                                     | span_mask(CFG_MODE_LSB, CFG_MODE_W)
                                     | span_mask(CFG_EN_LSB, 1)
                                     | span_mask(CFG_THR_LSB, CFG_THR_W);

endpackage

// File: rtl/csr_region_hit.sv
// Address window decoder for one register.
// Takes the subword index of the address (byte address without bit 0) and
// reports whether it falls inside [BASE, BASE + 2*NSUB). It also gives the
// subword offset within the register.
// Assumes BASE is subword aligned.
module csr_region_hit #(
    parameter int ADDR_W = 8,
    parameter int BASE   = 0,
    parameter int NSUB   = 1,
    parameter int IDX_W  = 1
) (
    input  logic [ADDR_W-2:0] word_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [ADDR_W-2:0] FIRST = (ADDR_W-1)'(BASE / 2);
    localparam logic [ADDR_W-2:0] COUNT = (ADDR_W-1)'(NSUB);

    logic [ADDR_W-2:0] offset;

    // Offset from the window start; an address below the window wraps high and misses
    always_comb begin
        offset = word_i - FIRST;
        hit_o  = offset < COUNT;
        idx_o  = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/csr_subword_reg.sv
// Software-writable register written one bus subword at a time.
// A write to subword k loads only the bits of that slice that MASK marks as
// field bits. Bits outside any field stay zero and so read back as zero.
// Assumes REG_W is a multiple of BUS_W. Reset is synchronous, active low.
module csr_subword_reg #(
    parameter int          REG_W = 64,
    parameter int          BUS_W = 16,
    parameter int          IDX_W = 2,
    parameter logic [63:0] MASK  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  q_o
);
    localparam int NSUB = REG_W / BUS_W;

    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        localparam logic [BUS_W-1:0] SLICE_MASK = MASK[k*BUS_W +: BUS_W];

        // Load the field bits of slice k when that subword is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o[k*BUS_W +: BUS_W] <= '0;
            end else if (wr_en_i && idx_i == IDX_W'(k)) begin
                q_o[k*BUS_W +: BUS_W] <= wdata_i & SLICE_MASK;
            end
        end
    end
endmodule

// File: rtl/csr_access_counter.sv
// Free-running access counter.
// Adds one for every cycle in which inc_i is high and wraps at 2^W.
// Software cannot load it. Reset is synchronous, active low.
module csr_access_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    // Count accesses, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n)     count_o <= '0;
        else if (inc_i) count_o <= count_o + W'(1);
    end
endmodule

// File: rtl/wide_csr_file.sv
// Wide register file behind a 16-bit request/acknowledge bus.
// Decodes byte addresses into register and subword. It holds the writable
// configuration register and the write-only arm bit, captures the hardware
// status inputs each cycle, and counts software accesses to the monitor
// fields. One access per request; the acknowledge and read data follow one
// cycle later. Assumes single-cycle requests. Reset is synchronous, active low.
module wide_csr_file
    import wide_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [BUS_W-1:0]      wdata_i,
    output logic                  ack_o,
    output logic [BUS_W-1:0]      rdata_o,
    output logic [CFG_BYTE_W-1:0] cfg_byte_o,
    output logic [CFG_MODE_W-1:0] cfg_mode_o,
    output logic                  cfg_en_o,
    output logic [CFG_THR_W-1:0]  cfg_thresh_o,
    output logic                  arm_o,
    input  logic [STA_W-1:0]      stat_a_i,
    input  logic [STB_W-1:0]      stat_b_i,
    input  logic [MONA_W-1:0]     mon_a_i,
    input  logic [MONB_W-1:0]     mon_b_i
);
    localparam int CFG_W = CFG_SUBS * BUS_W;
    localparam int STS_W = STS_SUBS * BUS_W;
    localparam int MON_W = MON_SUBS * BUS_W;

    logic [ADDR_W-2:0] word;
    logic              unused_addr_lsb;
    logic              hit_cfg, hit_sts, hit_mon, hit_cnt;
    logic [1:0]        idx_cfg, idx_mon;
    logic              idx_sts;
    logic              unused_cnt_idx;
    logic [CFG_W-1:0]  cfg_q;
    logic              arm_q;
    logic [STA_W-1:0]  sta_q;
    logic [STB_W-1:0]  stb_q;
    logic [MONA_W-1:0] mona_q;
    logic [MONB_W-1:0] monb_q;
    logic [STS_W-1:0]  sts_view;
    logic [MON_W-1:0]  mon_view;
    logic [CNT_W-1:0]  cnt_lo_q, cnt_hi_q;
    logic [MON_SUBS-1:0] touch_lo, touch_hi;
    logic              inc_lo, inc_hi;
    subword_t          rd_next;

    assign word            = addr_i[ADDR_W-1:1];
    assign unused_addr_lsb = addr_i[0];

    // ---------------- address decode ----------------
    csr_region_hit #(.ADDR_W(ADDR_W), .BASE(CFG_BASE), .NSUB(CFG_SUBS), .IDX_W(2)) u_hit_cfg (
        .word_i(word), .hit_o(hit_cfg), .idx_o(idx_cfg));
    csr_region_hit #(.ADDR_W(ADDR_W), .BASE(STS_BASE), .NSUB(STS_SUBS), .IDX_W(1)) u_hit_sts (
        .word_i(word), .hit_o(hit_sts), .idx_o(idx_sts));
    csr_region_hit #(.ADDR_W(ADDR_W), .BASE(MON_BASE), .NSUB(MON_SUBS), .IDX_W(2)) u_hit_mon (
        .word_i(word), .hit_o(hit_mon), .idx_o(idx_mon));
    csr_region_hit #(.ADDR_W(ADDR_W), .BASE(CNT_BASE), .NSUB(CNT_SUBS), .IDX_W(1)) u_hit_cnt (
        .word_i(word), .hit_o(hit_cnt), .idx_o(unused_cnt_idx));

    // ---------------- configuration register ----------------
    csr_subword_reg #(.REG_W(CFG_W), .BUS_W(BUS_W), .IDX_W(2), .MASK(CFG_MASK)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(req_i && we_i && hit_cfg),
        .idx_i(idx_cfg), .wdata_i(wdata_i), .q_o(cfg_q));

    assign cfg_byte_o   = cfg_q[CFG_BYTE_LSB +: CFG_BYTE_W];
    assign cfg_mode_o   = cfg_q[CFG_MODE_LSB +: CFG_MODE_W];
    assign cfg_en_o     = cfg_q[CFG_EN_LSB];
    assign cfg_thresh_o = cfg_q[CFG_THR_LSB +: CFG_THR_W];

    // Write-only arm bit: stored from the status subword that holds it, never read back
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else if (req_i && we_i && hit_sts && idx_sts == 1'(ARM_LSB / BUS_W))
            arm_q <= wdata_i[ARM_LSB % BUS_W];
    end
    assign arm_o = arm_q;

    // Capture hardware-driven fields on every clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q  <= '0;
            stb_q  <= '0;
            mona_q <= '0;
            monb_q <= '0;
        end else begin
            sta_q  <= stat_a_i;
            stb_q  <= stat_b_i;
            mona_q <= mon_a_i;
            monb_q <= mon_b_i;
        end
    end

    // Assemble the read views of the read-only registers from their fields
    always_comb begin
        sts_view = '0;
        sts_view[STA_LSB +: STA_W] = sta_q;
        sts_view[STB_LSB +: STB_W] = stb_q;
        mon_view = '0;
        mon_view[MONA_LSB +: MONA_W] = mona_q;
        mon_view[MONB_LSB +: MONB_W] = monb_q;
    end

    // ---------------- access counters ----------------
    for (genvar k = 0; k < MON_SUBS; k++) begin : g_touch
        assign touch_lo[k] = sub_overlaps(k, MONA_LSB, MONA_W);
        assign touch_hi[k] = sub_overlaps(k, MONB_LSB, MONB_W);
    end

    assign inc_lo = req_i && hit_mon && touch_lo[idx_mon];
    assign inc_hi = req_i && hit_mon && touch_hi[idx_mon];

    csr_access_counter #(.W(CNT_W)) u_cnt_lo (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_lo), .count_o(cnt_lo_q));
    csr_access_counter #(.W(CNT_W)) u_cnt_hi (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_hi), .count_o(cnt_hi_q));

    // ---------------- read path ----------------
    // Select the addressed subword; an unmapped address yields zero
    always_comb begin
        rd_next = '0;
        if (hit_cfg)      rd_next = cfg_q[int'(idx_cfg)*BUS_W +: BUS_W];
        else if (hit_sts) rd_next = sts_view[int'(idx_sts)*BUS_W +: BUS_W];
        else if (hit_mon) rd_next = mon_view[int'(idx_mon)*BUS_W +: BUS_W];
        else if (hit_cnt) rd_next = BUS_W'({cnt_hi_q, cnt_lo_q});
    end

    // Register the acknowledge and read data one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o   <= req_i;
            rdata_o <= (req_i && !we_i) ? rd_next : '0;
        end
    end
endmodule

// File: rtl/wide_csr_file_chk.sv
// Property checker for wide_csr_file, attached to it with bind.
// Watches the bus ports, the configuration outputs and the two access
// counters. Addresses match the register map in the brief.
module wide_csr_file_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        we_i,
    input logic [7:0]  addr_i,
    input logic        ack_o,
    input logic [15:0] rdata_o,
    input logic [19:0] cfg_all,
    input logic [7:0]  cnt_lo,
    input logic [7:0]  cnt_hi
);
    logic rd_req, wr_req, mapped, lo_hit, hi_hit;
    assign rd_req = req_i && !we_i;
    assign wr_req = req_i && we_i;
    assign mapped = addr_i[7:3] == 5'h00 || addr_i[7:2] == 6'h08 ||
                    addr_i[7:3] == 5'h05 || addr_i[7:1] == 7'h18;
    assign lo_hit = req_i && (addr_i[7:1] == 7'h14 || addr_i[7:1] == 7'h15);
    assign hi_hit = req_i && addr_i[7:1] == 7'h17;

    // R1
    req_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> ack_o);
    // R1
    idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_i |=> !ack_o);
    // R1
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_req |=> rdata_o == 16'h0);
    // R7
    arm_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && addr_i[7:1] == 7'h10) |=> !rdata_o[3]);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !mapped) |=> rdata_o == 16'h0);
    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && addr_i[7:3] == 5'h00) |=> $stable(cfg_all));
    // R8
    lo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_hit |=> cnt_lo == $past(cnt_lo) + 8'd1);
    // R8
    hi_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_hit |=> cnt_hi == $past(cnt_hi) + 8'd1);
    // R9
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !lo_hit |=> $stable(cnt_lo));
    // R9
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !hi_hit |=> $stable(cnt_hi));
endmodule

bind wide_csr_file wide_csr_file_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .ack_o(ack_o), .rdata_o(rdata_o),
    .cfg_all({cfg_byte_o, cfg_mode_o, cfg_en_o, cfg_thresh_o}),
    .cnt_lo(cnt_lo_q), .cnt_hi(cnt_hi_q));

// File: tb/wide_csr_file_bench.sv
// Bench for wide_csr_file. A behavioural model tracks the fields and counters
// and is compared with the outputs on every clock. Directed reads check the
// literal values given in the requirements.
module wide_csr_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [7:0]  cfg_byte, cfg_thresh;
    logic [2:0]  cfg_mode;
    logic        cfg_en, arm;
    logic [7:0]  stat_a = '0;
    logic [10:0] stat_b = '0;
    logic [19:0] mon_a = '0;
    logic [1:0]  mon_b = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    wide_csr_file u_wide_csr_file (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .ack_o(ack), .rdata_o(rdata),
        .cfg_byte_o(cfg_byte), .cfg_mode_o(cfg_mode), .cfg_en_o(cfg_en), .cfg_thresh_o(cfg_thresh),
        .arm_o(arm), .stat_a_i(stat_a), .stat_b_i(stat_b), .mon_a_i(mon_a), .mon_b_i(mon_b));

    // ---------------- reference model ----------------
    int m_byte, m_mode, m_en, m_thr, m_arm;
    int m_sa, m_sb, m_ma, m_mb, m_lo, m_hi;
    bit m_ack;
    logic [15:0] m_rd;

    function automatic logic [63:0] m_cfg_val();
        logic [63:0] v;
        v = 64'(m_byte) | (64'(m_mode) << 12) | (64'(m_en) << 36) | (64'(m_thr) << 40);
        return v;
    endfunction

    function automatic logic [15:0] m_read(input logic [7:0] a);
        int w;
        logic [63:0] v;
        w = int'(a) / 2;
        if (w <= 3)                v = m_cfg_val() >> (16 * w);
        else if (w == 16 || w == 17) v = ((64'(m_sa) << 12) | (64'(m_sb) << 20)) >> (16 * (w - 16));
        else if (w >= 20 && w <= 23) v = ((64'(m_ma) << 12) | (64'(m_mb) << 48)) >> (16 * (w - 20));
        else if (w == 24)          v = 64'((m_hi << 8) | m_lo);
        else                       v = '0;
        return v[15:0];
    endfunction

    // Advance the model at each edge: read, then writes, counters and input capture
    always @(posedge clk) begin
        if (!rst_n) begin
            m_byte = 0; m_mode = 0; m_en = 0; m_thr = 0; m_arm = 0;
            m_sa = 0; m_sb = 0; m_ma = 0; m_mb = 0; m_lo = 0; m_hi = 0;
            m_ack = 0; m_rd = '0;
        end else begin
            int w;
            logic [63:0] t;
            w = int'(addr) / 2;
            m_ack = req;
            m_rd  = (req && !we) ? m_read(addr) : 16'h0;
            if (req && we) begin
                if (w <= 3) begin
                    t = m_cfg_val();
                    t[16*w +: 16] = wdata;
                    m_byte = int'(t[7:0]); m_mode = int'(t[14:12]);
                    m_en = int'(t[36]);     m_thr = int'(t[47:40]);
                end
                if (w == 16) m_arm = int'(wdata[3]);
            end
            if (req && (w == 20 || w == 21)) m_lo = (m_lo + 1) % 256;
            if (req && w == 23)              m_hi = (m_hi + 1) % 256;
            m_sa = int'(stat_a); m_sb = int'(stat_b); m_ma = int'(mon_a); m_mb = int'(mon_b);
        end
    end

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Compare the design with the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(ack == m_ack, "R1 ack", 64'(ack), 64'(m_ack));
            check(rdata == m_rd, "R4 rdata", 64'(rdata), 64'(m_rd));
            check({cfg_byte, cfg_mode, cfg_en, cfg_thresh} ==
                  {m_byte[7:0], m_mode[2:0], m_en[0], m_thr[7:0]}, "R2 outputs",
                  64'({cfg_byte, cfg_mode, cfg_en, cfg_thresh}),
                  64'({m_byte[7:0], m_mode[2:0], m_en[0], m_thr[7:0]}));
            check(arm == m_arm[0], "R7 arm", 64'(arm), 64'(m_arm));
        end
    end

    // One bus access; returns the read data seen with the acknowledge
    task automatic bus(input logic [7:0] a, input logic w, input logic [15:0] d, output logic [15:0] rd);
        @(posedge clk); #1;
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0;
        check(ack == 1'b1, "R1 ack after request", 64'(ack), 64'h1);
        rd = rdata;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [15:0] exp, input string rq);
        logic [15:0] r;
        bus(a, 1'b0, 16'h0, r);
        check(r == exp, rq, 64'(r), 64'(exp));
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        logic [15:0] r;
        bus(a, 1'b1, d, r);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check({cfg_byte, cfg_mode, cfg_en, cfg_thresh} == '0, "R2 reset fields", 64'(cfg_byte), 64'h0);
        check(ack == 1'b0 && arm == 1'b0, "R7 arm reset", 64'(arm), 64'h0);
        rd_check(8'h30, 16'h0000, "R9 counters reset");

        // R3 subword writes
        wr(8'h00, 16'h1234); wr(8'h02, 16'h5678); wr(8'h04, 16'h9ABC); wr(8'h06, 16'hDEF1);
        check(cfg_byte == 8'h34, "R3 byte field", 64'(cfg_byte), 64'h34);
        check(cfg_mode == 3'h1, "R3 mode field", 64'(cfg_mode), 64'h1);
        check(cfg_en == 1'b1, "R3 enable field", 64'(cfg_en), 64'h1);
        check(cfg_thresh == 8'h9A, "R3 threshold field", 64'(cfg_thresh), 64'h9A);
        // R4 readback with unused bits zero
        rd_check(8'h00, 16'h1034, "R4 subword 0");
        rd_check(8'h02, 16'h0000, "R4 subword 1");
        rd_check(8'h04, 16'h9A10, "R4 subword 2");
        rd_check(8'h06, 16'h0000, "R4 subword 3");
        // R3 a single subword write leaves other slices alone
        wr(8'h04, 16'h0000);
        check(cfg_byte == 8'h34 && cfg_mode == 3'h1, "R3 other slice kept", 64'(cfg_byte), 64'h34);
        check(cfg_en == 1'b0 && cfg_thresh == 8'h00, "R3 slice cleared", 64'(cfg_thresh), 64'h0);
        rd_check(8'h01, 16'h1034, "R10 address bit 0 ignored");

        // R5 status register
        stat_a = 8'hAB; stat_b = 11'h4DE;
        rd_check(8'h20, 16'hB000, "R5 status low");
        rd_check(8'h22, 16'h4DEA, "R5 status high");
        // R7 write-only bit, R10 read-only bits ignore the write
        wr(8'h20, 16'hFFFF);
        check(arm == 1'b1, "R7 arm set", 64'(arm), 64'h1);
        rd_check(8'h20, 16'hB000, "R7 arm reads zero");
        wr(8'h20, 16'h0000);
        check(arm == 1'b0, "R7 arm cleared", 64'(arm), 64'h0);

        // R6 monitor register, each subword read twice
        mon_a = 20'hABCDE; mon_b = 2'h3;
        for (int p = 0; p < 2; p++) begin
            rd_check(8'h28, 16'hE000, "R6 monitor 0");
            rd_check(8'h2A, 16'hABCD, "R6 monitor 1");
            rd_check(8'h2C, 16'h0000, "R6 monitor 2");
            rd_check(8'h2E, 16'h0003, "R6 monitor 3");
        end
        rd_check(8'h30, 16'h0204, "R8 counter pattern");
        // R9 counters ignore writes
        wr(8'h30, 16'hFFFF);
        rd_check(8'h30, 16'h0204, "R9 write ignored");
        // R9 wrap of the low counter
        for (int i = 0; i < 252; i++) begin
            logic [15:0] r;
            bus(8'h28, 1'b0, 16'h0, r);
        end
        rd_check(8'h30, 16'h0200, "R9 low counter wrap");
        // R8 a write access also counts
        wr(8'h2E, 16'h1234);
        rd_check(8'h30, 16'h0300, "R8 write counted");
        rd_check(8'h2E, 16'h0003, "R10 read-only write ignored");

        // R10 unmapped addresses
        rd_check(8'h40, 16'h0000, "R10 unmapped read");
        wr(8'h08, 16'hFFFF);
        rd_check(8'h08, 16'h0000, "R10 unmapped write");
        rd_check(8'h00, 16'h1034, "R10 config untouched");
        repeat (2) @(posedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            finish_run();
        end
    end
endmodule